// File: doc/BRIEF.md
# Chip Timing Acquisition and Tracking

This block finds and then holds chip timing for a direct-sequence spread-spectrum receiver. Samples arrive as signed I/Q pairs, `SPC` samples per chip, against a repeating reference code of `NCHIP` chips. One code period therefore spans `L = NCHIP*SPC` samples. A free-running sample phase counts valid samples modulo `L`. Each candidate timing offset, or hypothesis, is scored over exactly one code period, and that period ends when the phase reaches `L-1`.

While searching, the block tests one hypothesis per period. It uses one sample per chip, correlates the I and Q streams separately and adds their squares. It then compares that energy with a programmable threshold. On the first strict pass it hands the offset to a tracking loop and raises `locked`. The tracking loop is a non-coherent delay-locked loop. It correlates every sample of a period at half a chip early and half a chip late. It integrates the energy difference in a scaled first-order filter, and it moves the offset one sample whenever the filter reaches a programmable bound.

The demodulator consumes the current offset together with a chip strobe and a code-start strobe.

Top module: `cta_chip_sync`

## Requirements
- R1: While reset is held and right after it, `locked` is 0, `timing_off` is 0 and both strobes are 0.
- R2: For hypothesis h, the search metric over one period is CI²+CQ². CI sums the I samples whose index p = (phase − h) mod L is a multiple of SPC, each weighted +1 if bit p/SPC of `ref_chips` is 1 and −1 if it is 0. CQ does the same for the Q samples.
- R3: A hypothesis passes only if its metric is strictly greater than `acq_thresh`. On the clock edge that takes the last sample of the passing period, `locked` rises and the offset becomes that hypothesis.
- R4: A hypothesis that fails is replaced by the next one. Hypothesis L−1 is followed by 0, so the sweep restarts. While unlocked, `timing_off` shows the hypothesis under test.
- R5: Once set, `locked` stays 1 until reset.
- R6: While locked, each period forms an early energy at offset−SPC/2 and a late energy at offset+SPC/2 (both mod L). Both use every sample with the R2 weighting, and the loop error is early minus late.
- R7: At each period end the filter adds error>>>KSH (arithmetic shift). A result ≥ `step_thresh` decrements the offset mod L, and a result ≤ −`step_thresh` increments it; either step clears the filter. Otherwise the filter keeps the sum. The offset moves at most one sample per period.
- R8: `chip_stb` is 1 when a valid sample arrives while locked and (phase − offset) mod L is a multiple of SPC. `sym_stb` is 1 under the same conditions when that value is 0.
- R9: Cycles with `smp_valid` low have no effect: the phase, search, loop and outputs are unchanged and both strobes stay 0, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample pair is present this cycle |
| smp_i | input | W | In-phase sample, signed |
| smp_q | input | W | Quadrature sample, signed |
| ref_chips | input | NCHIP | Reference code, bit k is chip k (1 → +1, 0 → −1) |
| acq_thresh | input | 2·AW+1 | Search energy threshold (AW = W+clog2(L)+1) |
| step_thresh | input | LW−1 | Loop filter bound that triggers a one-sample step |
| locked | output | 1 | Tracking active |
| timing_off | output | clog2(L) | Offset under test, or tracked offset once locked |
| chip_stb | output | 1 | Chip boundary strobe for the demodulator |
| sym_stb | output | 1 | Code-start strobe for the demodulator |

## Verification
The embedded assertions cover the properties that hold on every cycle. `locked` never falls outside reset. The hypothesis stays in range and advances by exactly one, with wrap-around. The tracked offset changes only at a period end or at handoff, and then by a single sample. A code-start strobe is always also a chip strobe.

Only the bench scenarios can show the arithmetic. These include the exact period on which the handoff occurs, the strict threshold comparison at equality and a full double sweep with no lock. They also include the direction and timing of loop steps after the delay shifts by one sample, and the insensitivity to invalid cycles carrying junk samples. The bench covers all sixteen delays of one code, plus a slow-integrating loop case.

// File: rtl/cta_pkg.sv
package cta_pkg;

   typedef enum int {
      TAP_EARLY = 0,
      TAP_LATE  = 1
   } tap_e;

   // (a - b) mod m for operands already in [0, m)
   function automatic int mod_sub(int a, int b, int m);
      int d;
      d = a - b;
      if (d < 0) d = d + m;
      return d;
   endfunction

endpackage

// File: rtl/cta_lane.sv
module cta_lane #(
   parameter int W  = 4,
   parameter int AW = 9
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic                 use_smp,
   input  logic                 plus_sgn,
   input  logic                 dump,
   input  logic signed [W-1:0]  smp,
   output logic signed [AW-1:0] total
);

   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] ext;
   logic signed [AW-1:0] term;

   assign ext = AW'(smp);

   always_comb begin
      if (!use_smp)      term = '0;
      else if (plus_sgn) term = ext;
      else               term = -ext;
   end

   // running sum including the sample of this cycle
   assign total = acc + term;

   always_ff @(posedge clk) begin
      if (!rst_n)   acc <= '0;
      else if (adv) acc <= dump ? '0 : total;
   end

endmodule

// File: rtl/cta_acq.sv
module cta_acq #(
   parameter int W     = 4,
   parameter int NCHIP = 8,
   parameter int SPC   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic [$clog2(NCHIP*SPC)-1:0] ph,
   input  logic signed [W-1:0]     smp_i,
   input  logic signed [W-1:0]     smp_q,
   input  logic [NCHIP-1:0]        ref_chips,
   input  logic [2*(W+$clog2(NCHIP*SPC)+1):0] thresh,
   output logic [$clog2(NCHIP*SPC)-1:0] hyp,
   output logic                    hit
);

   localparam int L  = NCHIP * SPC;
   localparam int PW = $clog2(L);
   localparam int AW = W + $clog2(L) + 1;
   localparam int MW = 2 * AW + 1;
   localparam int CW = $clog2(NCHIP);

   int                   pp;
   logic                 use_smp;
   logic                 plus_sgn;
   logic                 dump;
   logic signed [AW-1:0] tot_i, tot_q;
   logic signed [2*AW-1:0] sq_i, sq_q;
   logic [MW-1:0]        metric;

   always_comb begin
      pp       = cta_pkg::mod_sub(int'(ph), int'(hyp), L);
      use_smp  = (pp % SPC) == 0;
      plus_sgn = ref_chips[CW'(pp / SPC)];
   end

   assign dump = (ph == PW'(L - 1));

   cta_lane #(.W(W), .AW(AW)) u_lane_i (
      .clk(clk), .rst_n(rst_n), .adv(run), .use_smp(use_smp),
      .plus_sgn(plus_sgn), .dump(dump), .smp(smp_i), .total(tot_i));

   cta_lane #(.W(W), .AW(AW)) u_lane_q (
      .clk(clk), .rst_n(rst_n), .adv(run), .use_smp(use_smp),
      .plus_sgn(plus_sgn), .dump(dump), .smp(smp_q), .total(tot_q));

   assign sq_i   = (2*AW)'(tot_i) * (2*AW)'(tot_i);
   assign sq_q   = (2*AW)'(tot_q) * (2*AW)'(tot_q);
   assign metric = MW'($unsigned(sq_i)) + MW'($unsigned(sq_q));
   assign hit    = run && dump && (metric > thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) hyp <= '0;
      else if (run && dump && !hit)
         hyp <= (hyp == PW'(L - 1)) ? '0 : hyp + 1'b1;
   end

   assert_hyp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(hyp) < L);

   assert_hyp_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hyp != $past(hyp)) |->
         (int'(hyp) == (int'($past(hyp)) + 1) % L));

endmodule

// File: rtl/cta_dll.sv
module cta_dll #(
   parameter int W     = 4,
   parameter int NCHIP = 8,
   parameter int SPC   = 2,
   parameter int KSH   = 2,
   parameter int LW    = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    load,
   input  logic [$clog2(NCHIP*SPC)-1:0] load_off,
   input  logic [$clog2(NCHIP*SPC)-1:0] ph,
   input  logic signed [W-1:0]     smp_i,
   input  logic signed [W-1:0]     smp_q,
   input  logic [NCHIP-1:0]        ref_chips,
   input  logic [LW-2:0]           step_thresh,
   output logic [$clog2(NCHIP*SPC)-1:0] off
);

   localparam int L    = NCHIP * SPC;
   localparam int PW   = $clog2(L);
   localparam int AW   = W + $clog2(L) + 1;
   localparam int MW   = 2 * AW + 1;
   localparam int CW   = $clog2(NCHIP);
   localparam int HALF = SPC / 2;

   logic                 dump;
   logic [MW-1:0]        tap_met [2];
   logic signed [MW:0]   err;
   logic signed [LW-1:0] err_x, err_sh, acc, acc_next, thr_s;
   logic [PW-1:0]        off_inc, off_dec;

   assign dump = (ph == PW'(L - 1));

   for (genvar g = 0; g < 2; g++) begin : g_tap
      localparam int SHIFT = (g == int'(cta_pkg::TAP_EARLY)) ? HALF : L - HALF;
      int                   tpos, pp;
      logic                 plus_sgn;
      logic signed [AW-1:0] tot_i, tot_q;
      logic signed [2*AW-1:0] sq_i, sq_q;

      always_comb begin
         tpos     = cta_pkg::mod_sub(int'(off), SHIFT, L);
         pp       = cta_pkg::mod_sub(int'(ph), tpos, L);
         plus_sgn = ref_chips[CW'(pp / SPC)];
      end

      cta_lane #(.W(W), .AW(AW)) u_lane_i (
         .clk(clk), .rst_n(rst_n), .adv(run), .use_smp(1'b1),
         .plus_sgn(plus_sgn), .dump(dump), .smp(smp_i), .total(tot_i));

      cta_lane #(.W(W), .AW(AW)) u_lane_q (
         .clk(clk), .rst_n(rst_n), .adv(run), .use_smp(1'b1),
         .plus_sgn(plus_sgn), .dump(dump), .smp(smp_q), .total(tot_q));

      assign sq_i       = (2*AW)'(tot_i) * (2*AW)'(tot_i);
      assign sq_q       = (2*AW)'(tot_q) * (2*AW)'(tot_q);
      assign tap_met[g] = MW'($unsigned(sq_i)) + MW'($unsigned(sq_q));
   end

   assign err   = $signed({1'b0, tap_met[cta_pkg::TAP_EARLY]})
                - $signed({1'b0, tap_met[cta_pkg::TAP_LATE]});
   assign err_x = LW'(err);

   if (KSH == 0) begin : g_noscale
      assign err_sh = err_x;
   end else begin : g_scale
      assign err_sh = err_x >>> KSH;
   end

   assign acc_next = acc + err_sh;
   assign thr_s    = $signed({1'b0, step_thresh});
   assign off_inc  = (off == PW'(L - 1)) ? '0 : off + 1'b1;
   assign off_dec  = (off == '0) ? PW'(L - 1) : off - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off <= '0;
         acc <= '0;
      end else if (load) begin
         off <= load_off;
         acc <= '0;
      end else if (run && dump) begin
         if (acc_next >= thr_s) begin
            off <= off_dec;
            acc <= '0;
         end else if (acc_next <= -thr_s) begin
            off <= off_inc;
            acc <= '0;
         end else begin
            acc <= acc_next;
         end
      end
   end

   assert_off_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && off != $past(off)) |->
         (off == $past(off_inc) || off == $past(off_dec)));

   assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && !$past(run && dump)) |-> $stable(off));

endmodule

// File: rtl/cta_chip_sync.sv
module cta_chip_sync #(
   parameter int W     = 4,
   parameter int NCHIP = 8,
   parameter int SPC   = 2,
   parameter int KSH   = 2,
   parameter int LW    = 24,
   localparam int L    = NCHIP * SPC,
   localparam int PW   = $clog2(L),
   localparam int AW   = W + $clog2(L) + 1,
   localparam int MW   = 2 * AW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic signed [W-1:0]  smp_i,
   input  logic signed [W-1:0]  smp_q,
   input  logic [NCHIP-1:0]     ref_chips,
   input  logic [MW-1:0]        acq_thresh,
   input  logic [LW-2:0]        step_thresh,
   output logic                 locked,
   output logic [PW-1:0]        timing_off,
   output logic                 chip_stb,
   output logic                 sym_stb
);

   if (SPC < 2 || (SPC % 2) != 0) begin : g_bad_spc
      $error("cta_chip_sync: SPC must be even and at least 2");
   end
   if (NCHIP < 2) begin : g_bad_nchip
      $error("cta_chip_sync: NCHIP must be at least 2");
   end
   if (LW < MW + 2 || KSH >= LW) begin : g_bad_lw
      $error("cta_chip_sync: loop width too small for the error or shift");
   end

   logic [PW-1:0] ph;
   logic [PW-1:0] acq_hyp, dll_off;
   logic          acq_hit;
   logic          run_acq, run_dll;
   int            spp;

   assign run_acq = smp_valid && !locked;
   assign run_dll = smp_valid && locked;

   always_ff @(posedge clk) begin
      if (!rst_n) ph <= '0;
      else if (smp_valid) ph <= (ph == PW'(L - 1)) ? '0 : ph + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       locked <= 1'b0;
      else if (acq_hit) locked <= 1'b1;
   end

   cta_acq #(.W(W), .NCHIP(NCHIP), .SPC(SPC)) u_acq (
      .clk(clk), .rst_n(rst_n), .run(run_acq), .ph(ph),
      .smp_i(smp_i), .smp_q(smp_q), .ref_chips(ref_chips),
      .thresh(acq_thresh), .hyp(acq_hyp), .hit(acq_hit));

   cta_dll #(.W(W), .NCHIP(NCHIP), .SPC(SPC), .KSH(KSH), .LW(LW)) u_dll (
      .clk(clk), .rst_n(rst_n), .run(run_dll), .load(acq_hit),
      .load_off(acq_hyp), .ph(ph), .smp_i(smp_i), .smp_q(smp_q),
      .ref_chips(ref_chips), .step_thresh(step_thresh), .off(dll_off));

   assign timing_off = locked ? dll_off : acq_hyp;

   always_comb spp = cta_pkg::mod_sub(int'(ph), int'(dll_off), L);

   assign chip_stb = smp_valid && locked && ((spp % SPC) == 0);
   assign sym_stb  = smp_valid && locked && (spp == 0);

   assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   assert_handoff_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (timing_off == $past(acq_hyp)));

   assert_sym_within_chip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sym_stb |-> chip_stb);

   assert_strobe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |-> (!chip_stb && !sym_stb));

endmodule

// File: tb/cta_chip_sync_tb.sv
module cta_chip_sync_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W     = 4;
   localparam int NCHIP = 8;
   localparam int SPC   = 2;
   localparam int KSH   = 2;
   localparam int LW    = 24;
   localparam int L     = NCHIP * SPC;
   localparam int PW    = $clog2(L);
   localparam int HALF  = SPC / 2;
   localparam int AW    = W + $clog2(L) + 1;
   localparam int MW    = 2 * AW + 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                smp_valid = 1'b0;
   logic signed [W-1:0] smp_i = '0;
   logic signed [W-1:0] smp_q = '0;
   logic [NCHIP-1:0]    ref_chips = '0;
   logic [MW-1:0]       acq_thresh = '0;
   logic [LW-2:0]       step_thresh = '0;
   logic                locked;
   logic [PW-1:0]       timing_off;
   logic                chip_stb;
   logic                sym_stb;

   cta_chip_sync #(.W(W), .NCHIP(NCHIP), .SPC(SPC), .KSH(KSH), .LW(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i),
      .smp_q(smp_q), .ref_chips(ref_chips), .acq_thresh(acq_thresh),
      .step_thresh(step_thresh), .locked(locked), .timing_off(timing_off),
      .chip_stb(chip_stb), .sym_stb(sym_stb));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference model state
   int m_n, m_d, m_ai, m_aq, m_beta, m_thr, m_off, m_acc;
   bit m_locked;
   logic [NCHIP-1:0] m_ref;

   task automatic chk(bit ok, string req, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (sample %0d)", req, act, exp, m_n);
      end
   endtask

   function automatic int md(int a);
      return ((a % L) + L) % L;
   endfunction

   function automatic int sgn(int k);
      return m_ref[k] ? 1 : -1;
   endfunction

   function automatic int xval(int k, int d, int a);
      return a * sgn(md(k - d) / SPC);
   endfunction

   // energy at timing t for delay d; chip_rate picks one sample per chip
   function automatic int energy(int t, int d, bit chip_rate);
      int ci = 0;
      int cq = 0;
      for (int k = 0; k < L; k++) begin
         int p;
         p = md(k - t);
         if (!chip_rate || (p % SPC) == 0) begin
            ci += xval(k, d, m_ai) * sgn(p / SPC);
            cq += xval(k, d, m_aq) * sgn(p / SPC);
         end
      end
      return ci * ci + cq * cq;
   endfunction

   task automatic step(bit gap);
      int ph, pp, junk, e, l, an;
      if (gap) begin
         junk = m_n * 5 + 3;
         smp_valid = 1'b0;
         smp_i = W'(junk);
         smp_q = W'(~junk);
         #1;
         chk(!chip_stb && !sym_stb, "R9", int'(chip_stb) + int'(sym_stb), 0);
         @(negedge clk);
         chk(locked == m_locked, "R9", int'(locked), int'(m_locked));
         chk(int'(timing_off) == m_off, "R9", int'(timing_off), m_off);
      end
      ph = m_n % L;
      smp_valid = 1'b1;
      smp_i = W'(xval(m_n, m_d, m_ai));
      smp_q = W'(xval(m_n, m_d, m_aq));
      #1;
      pp = md(ph - m_off);
      chk(chip_stb == (m_locked && (pp % SPC) == 0), "R8", int'(chip_stb),
          int'(m_locked && (pp % SPC) == 0));
      chk(sym_stb == (m_locked && pp == 0), "R8", int'(sym_stb), int'(m_locked && pp == 0));
      @(posedge clk);
      if (ph == L - 1) begin
         if (!m_locked) begin
            // R2 metric, R3 strict compare, R4 next hypothesis
            if (energy(m_off, m_d, 1'b1) > m_beta) m_locked = 1'b1;
            else m_off = (m_off + 1) % L;
         end else begin
            // R6 early minus late, R7 filter and step
            e  = energy(md(m_off - HALF), m_d, 1'b0);
            l  = energy(md(m_off + HALF), m_d, 1'b0);
            an = m_acc + ((e - l) >>> KSH);
            if (an >= m_thr) begin
               m_off = md(m_off - 1);
               m_acc = 0;
            end else if (an <= -m_thr) begin
               m_off = md(m_off + 1);
               m_acc = 0;
            end else begin
               m_acc = an;
            end
         end
      end
      m_n++;
      @(negedge clk);
      if (ph == L - 1) begin
         chk(locked == m_locked, "R3", int'(locked), int'(m_locked));
         chk(int'(timing_off) == m_off, m_locked ? "R7" : "R4", int'(timing_off), m_off);
      end
   endtask

   task automatic scen(logic [NCHIP-1:0] rc, int d0, int ai, int aq, int bdelta,
                       int thr, int d1, int shift_p, int nper, bit gaps);
      int peak = 0;
      rst_n = 1'b0;
      smp_valid = 1'b1;
      ref_chips = rc;
      m_ref = rc;
      m_ai = ai;
      m_aq = aq;
      for (int h = 0; h < L; h++) begin
         int v;
         v = energy(h, d0, 1'b1);
         if (v > peak) peak = v;
      end
      m_beta = peak + bdelta;
      m_thr = thr;
      acq_thresh = MW'(m_beta);
      step_thresh = (LW-1)'(thr);
      repeat (3) @(negedge clk);
      chk(locked == 1'b0, "R1", int'(locked), 0);
      chk(timing_off == '0, "R1", int'(timing_off), 0);
      chk(!chip_stb && !sym_stb, "R1", int'(chip_stb) + int'(sym_stb), 0);
      smp_valid = 1'b0;
      rst_n = 1'b1;
      m_n = 0;
      m_d = d0;
      m_off = 0;
      m_acc = 0;
      m_locked = 1'b0;
      @(negedge clk);
      chk(locked == 1'b0 && timing_off == '0, "R1", int'(locked), 0);
      for (int p = 0; p < nper; p++) begin
         if (p == shift_p) m_d = d1;
         for (int s = 0; s < L; s++) step(gaps && (s % 5) == 2);
      end
      if (bdelta < 0) chk(locked == 1'b1, "R5", int'(locked), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual 0 expected 1 (run completion)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // every delay, alternating shift direction, some with invalid gaps (R9)
      for (int d = 0; d < L; d++) begin
         scen(8'b1011_0001, d, 5, -3, -1, 300,
              (d % 2 == 1) ? md(d + 1) : md(d - 1), L + 1, L + 10, (d % 4) == 3);
      end
      // slow loop: large bound, error integrates over several periods (R7)
      scen(8'b0110_1101, 5, 7, 0, -1, 20000, 6, L + 2, L + 30, 1'b0);
      // threshold equal to the peak never passes: double sweep, no lock (R3, R4)
      scen(8'b1011_0001, 3, 5, -3, 0, 300, 3, 1000, 2 * L + 2, 1'b0);
      chk(locked == 1'b0, "R3", int'(locked), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule